// File: doc/BRIEF.md
# Prefix-Routed SPI Control Slave

This block is the serial control front end of a small board controller. A host talks to it over a four-wire SPI link in mode 0: the clock idles low, both ends sample on the rising edge, the most significant bit goes first and the chip select is active low. The first seven bits of every transaction are an address, and the eighth is a flag bit. The address decides how the rest of the frame is treated. It can be a 16-bit register access, a load of one of four 8-bit attenuator words, or a transparent connection to one of four downstream SPI devices, typically PLL synthesizers, that stays open for as long as the host holds chip select low.

The host lines are brought into the system clock through two-flop synchronizers, and edges are detected there. Register writes and attenuator loads only take effect when chip select rises at the correct frame length, so a truncated or overlong frame leaves every piece of state unchanged. In passthrough, the host clock and data go straight to the selected device, gated by registered enables. The data that device returns is steered back onto the host MISO line.

Top module: `spr_router`

## Requirements
- R1: Bits are sampled on the rising SCK edge, MSB first. Frame bits 0..6 are the address (MSB first) and bit 7 is the flag. A value written and then read back, such as 16'h8001, comes back with the same bit order.
- R2: A 24-bit frame to address 1, 2 or 3 with flag = 1 stores its last 16 bits into that register when CS_n rises.
- R3: A 24-bit frame to address 0..3 with flag = 0 returns that register on MISO during bits 8..23, MSB first. MISO is 0 during bits 0..7. Downstream MISO lines have no effect on it.
- R4: Register 0 is read-only. Bits [1:0] = 2'b11, bits [3:2] = 2'b00, bit 8+n is the live `pll_stat[n]`, and all other bits are 0. A write to address 0 changes nothing.
- R5: After reset, registers 1..3 read 0, every attenuator word is 0, all downstream chip selects are high and MISO is 0.
- R6: A 16-bit frame to address 8+n (n = 0..3) with flag = 0 latches its last 8 bits into `att[8n+7:8n]`. If the flag is 1, the frame is ignored.
- R7: A frame to address 4+n with flag = 0 drives `dn_cs_n[n]` low after the eighth bit. From then until CS_n rises, SCK and MOSI are forwarded to port n, and `dn_miso[n]` is returned on MISO. Exactly the post-prefix clock edges reach the device.
- R8: At most one downstream chip select is low at a time, and none is low outside a passthrough frame. An unselected port sees no SCK edges.
- R9: An address outside 0..11, or an address in 4..7 with flag = 1, returns MISO = 0 and changes no register, attenuator or downstream pin.
- R10: A frame whose length at CS_n rise differs from its kind (24 bits for registers, 16 for attenuators) updates nothing.
- R11: The system clock runs at least 8 times faster than SCK. A register or attenuator update is visible within 4 system clocks after CS_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Host SPI clock |
| mosi | input | 1 | Host serial data in |
| cs_n | input | 1 | Host chip select, active low |
| miso | output | 1 | Host serial data out |
| dn_sck | output | NCH | Downstream SPI clocks |
| dn_mosi | output | NCH | Downstream serial data |
| dn_cs_n | output | NCH | Downstream chip selects, active low |
| dn_miso | input | NCH | Downstream serial data returned |
| pll_stat | input | NCH | PLL status lines shown in register 0 |
| att | output | NCH*ATT_W | Attenuator words, channel n at [8n+7:8n] |

## Verification
Every internal decision comes three system clocks after the host edge that causes it: two synchronizer stages and one register. A commit at CS_n rise is checked at the fourth falling system clock after the bench raises CS_n, which is the latest point R11 allows. Read data and the passthrough chip select settle within three clocks after the eighth SCK rise. The bench holds each SCK phase for eight system clocks and samples MISO just before it raises SCK, so every sampled bit has had at least five clocks to settle. The downstream model counts its clock edges, and this shows that none leak out before the chip select falls.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {FR_NONE, FR_REG, FR_PASS, FR_ATT} frame_kind_t;
  localparam logic [1:0] HW_REV    = 2'b11;
  localparam logic [1:0] PROTO_REV = 2'b00;
  localparam int         STAT_LSB  = 8;
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spr_rx.sv
module spr_rx #(
  parameter int ADDR_W = 7,
  parameter int SH_W = 16,
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              cs_s,
  output logic              bit_rise,
  output logic              prefix_done,
  output logic [ADDR_W-1:0] pfx_addr,
  output logic              pfx_flag,
  output logic              frame_end,
  output logic [CNT_W-1:0]  frame_bits,
  output logic [SH_W-1:0]   frame_data
);
  localparam int PFX_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sck_d, cs_d;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0] sh;

  assign bit_rise    = ~cs_s & sck_s & ~sck_d;
  assign frame_end   = cs_s & ~cs_d;
  assign prefix_done = bit_rise && (cnt == CNT_W'(PFX_W - 1));
  assign pfx_addr    = sh[ADDR_W-1:0];
  assign pfx_flag    = mosi_s;
  assign frame_bits  = cnt;
  assign frame_data  = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
      if (cs_s) begin
        cnt <= '0;
      end else if (bit_rise) begin
        sh <= {sh[SH_W-2:0], mosi_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  // R10: the bit count restarts whenever the host is deselected
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (frame_bits == '0));
endmodule

// File: rtl/spr_regbank.sv
module spr_regbank
  import spr_pkg::*;
#(
  parameter int DW = 16,
  parameter int NREG = 4,
  parameter int NCH = 4,
  localparam int RI_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RI_W-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [RI_W-1:0] rd_idx,
  output logic [DW-1:0]   rd_data,
  input  logic [NCH-1:0]  pll_s
);
  logic [DW-1:0] store [1:NREG-1];
  logic [DW-1:0] view [NREG];
  logic [DW-1:0] id_word;

  always_comb begin
    id_word = '0;
    id_word[1:0] = HW_REV;
    id_word[3:2] = PROTO_REV;
    id_word[STAT_LSB +: NCH] = pll_s;
  end

  assign view[0] = id_word;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) store[g] <= '0;
      else if (wr_en && wr_idx == RI_W'(g)) store[g] <= wr_data;
    end
    assign view[g] = store[g];
  end

  assign rd_data = view[rd_idx];

  // R2: a committed write is visible on the next cycle
  p_wr_commit_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0) |=> (view[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/spr_router.sv
module spr_router
  import spr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int ADDR_W = 7,
  parameter int DW = 16,
  parameter int ATT_W = 8,
  parameter int NREG = 4,
  parameter int PASS_BASE = 4,
  parameter int ATT_BASE = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck,
  input  logic                 mosi,
  input  logic                 cs_n,
  output logic                 miso,
  output logic [NCH-1:0]       dn_sck,
  output logic [NCH-1:0]       dn_mosi,
  output logic [NCH-1:0]       dn_cs_n,
  input  logic [NCH-1:0]       dn_miso,
  input  logic [NCH-1:0]       pll_stat,
  output logic [NCH*ATT_W-1:0] att
);
  localparam int PFX_W     = ADDR_W + 1;
  localparam int REG_FRAME = PFX_W + DW;
  localparam int ATT_FRAME = PFX_W + ATT_W;
  localparam int CNT_W     = $clog2(REG_FRAME + 2);
  localparam int CH_W      = $clog2(NCH);
  localparam int RI_W      = $clog2(NREG);

  logic sck_s, mosi_s, cs_s;
  logic [NCH-1:0] pll_s;
  logic bit_rise, prefix_done, pfx_flag, frame_end;
  logic [ADDR_W-1:0] pfx_addr;
  logic [CNT_W-1:0] frame_bits;
  logic [DW-1:0] frame_data, rd_data;

  spr_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_host_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, mosi}), .q({cs_s, sck_s, mosi_s}));

  spr_sync #(.W(NCH), .STAGES(2), .RST_VAL('0)) u_stat_sync (
    .clk(clk), .rst(rst), .d(pll_stat), .q(pll_s));

  spr_rx #(.ADDR_W(ADDR_W), .SH_W(DW), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .sck_s(sck_s), .mosi_s(mosi_s), .cs_s(cs_s),
    .bit_rise(bit_rise), .prefix_done(prefix_done), .pfx_addr(pfx_addr),
    .pfx_flag(pfx_flag), .frame_end(frame_end), .frame_bits(frame_bits),
    .frame_data(frame_data));

  // prefix decode
  frame_kind_t kind_c, kind_q;
  logic [CH_W-1:0] ch_c, ch_q;
  logic [RI_W-1:0] ri_c, ri_q;
  logic flag_q;

  always_comb begin
    kind_c = FR_NONE;
    ch_c = '0;
    ri_c = '0;
    for (int i = 0; i < NREG; i++)
      if (pfx_addr == ADDR_W'(i)) begin kind_c = FR_REG; ri_c = RI_W'(i); end
    for (int i = 0; i < NCH; i++) begin
      if (pfx_addr == ADDR_W'(PASS_BASE + i)) begin kind_c = FR_PASS; ch_c = CH_W'(i); end
      if (pfx_addr == ADDR_W'(ATT_BASE + i))  begin kind_c = FR_ATT;  ch_c = CH_W'(i); end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (cs_s && !frame_end)) begin
      kind_q <= FR_NONE;
      flag_q <= 1'b0;
      ch_q   <= '0;
      ri_q   <= '0;
    end else if (prefix_done) begin
      kind_q <= kind_c;
      flag_q <= pfx_flag;
      ch_q   <= ch_c;
      ri_q   <= ri_c;
    end
  end

  // register bank
  logic wr_en;
  assign wr_en = frame_end && kind_q == FR_REG && flag_q &&
                 frame_bits == CNT_W'(REG_FRAME);

  spr_regbank #(.DW(DW), .NREG(NREG), .NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(ri_q), .wr_data(frame_data),
    .rd_idx(ri_c), .rd_data(rd_data), .pll_s(pll_s));

  // read-back shifter
  logic [DW-1:0] read_sh;
  always_ff @(posedge clk) begin
    if (rst || cs_s) read_sh <= '0;
    else if (prefix_done) read_sh <= (kind_c == FR_REG && !pfx_flag) ? rd_data : '0;
    else if (bit_rise && frame_bits >= CNT_W'(PFX_W)) read_sh <= {read_sh[DW-2:0], 1'b0};
  end

  // attenuator words
  logic [NCH-1:0][ATT_W-1:0] att_q;
  always_ff @(posedge clk) begin
    if (rst) att_q <= '0;
    else if (frame_end && kind_q == FR_ATT && !flag_q &&
             frame_bits == CNT_W'(ATT_FRAME))
      att_q[ch_q] <= frame_data[ATT_W-1:0];
  end
  assign att = att_q;

  // passthrough routing
  logic [NCH-1:0] dn_cs_q;
  logic clk_en_q;
  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      dn_cs_q  <= '1;
      clk_en_q <= 1'b0;
    end else begin
      if (prefix_done && kind_c == FR_PASS && !pfx_flag)
        dn_cs_q <= ~(NCH'(1) << ch_c);
      if (!(&dn_cs_q) && !sck_s) clk_en_q <= 1'b1;
    end
  end

  assign dn_cs_n = dn_cs_q;
  assign dn_sck  = {NCH{sck & clk_en_q}} & ~dn_cs_q;
  assign dn_mosi = {NCH{mosi}} & ~dn_cs_q;
  assign miso    = (&dn_cs_q) ? read_sh[DW-1] : |(dn_miso & ~dn_cs_q);

  // R8: one downstream select at most, none while host is idle
  p_dn_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dn_cs_q));
  p_dn_idle_r8: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (&dn_cs_q));
  // R7: downstream clock gate never open without a select
  p_clk_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (&dn_cs_q) |-> !clk_en_q);
  // R9: read data is cleared between frames
  p_read_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (read_sh == '0));
  // R10: attenuator words move only at a frame end
  p_att_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(att_q));
endmodule

// File: tb/spr_router_test.sv
module spr_router_test;
  localparam int NCH = 4;
  localparam int ATT_W = 8;
  localparam logic [31:0] DS_PAT = 32'h3C5A_9617;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [NCH-1:0] dn_sck, dn_mosi, dn_cs_n, dn_miso;
  logic [NCH-1:0] pll_stat = 4'b1010;
  logic [NCH*ATT_W-1:0] att;

  always #5 clk = ~clk;

  spr_router uut (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .dn_sck(dn_sck), .dn_mosi(dn_mosi), .dn_cs_n(dn_cs_n), .dn_miso(dn_miso),
    .pll_stat(pll_stat), .att(att));

  // downstream device model on port 2; others return constant ones
  logic [31:0] ds_in = '0;
  int ds_edges = 0, ds_base = 0, other_edges = 0;
  logic ds_bit;
  always @(posedge dn_sck[2]) begin ds_in = {ds_in[30:0], dn_mosi[2]}; ds_edges++; end
  always @(negedge dn_cs_n[2]) ds_base = ds_edges;
  always @(posedge dn_sck[0] or posedge dn_sck[1] or posedge dn_sck[3]) other_edges++;
  always @* begin
    int k;
    k = ds_edges - ds_base;
    ds_bit = (k >= 0 && k < 32) ? DS_PAT[31-k] : 1'b0;
  end
  assign dn_miso = {1'b1, ds_bit, 1'b1, 1'b1};

  // scoreboard
  typedef struct {int src; int arg; logic [31:0] exp; string req;} item_t;
  item_t sb[$];
  event chk_ev;
  int n_chk = 0, n_fail = 0;
  logic [63:0] got;
  logic [NCH-1:0] mid_cs;
  bit done = 0;

  function automatic logic [31:0] observe(int src, int arg);
    case (src)
      0: return got[31:0];
      1: return 32'(att[arg*ATT_W +: ATT_W]);
      2: return 32'(dn_cs_n);
      3: return ds_in;
      4: return 32'(ds_edges);
      5: return 32'(other_edges);
      6: return 32'(miso);
      7: return 32'(mid_cs);
      default: return 32'hDEAD_BEEF;
    endcase
  endfunction

  task automatic expect_val(int src, int arg, logic [31:0] exp, string req);
    item_t it;
    it.src = src; it.arg = arg; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic settle();
    -> chk_ev;
    @(negedge clk);
  endtask

  initial forever begin
    @(chk_ev);
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] a;
      it = sb.pop_front();
      a = observe(it.src, it.arg);
      n_chk++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s: source %0d/%0d actual %h expected %h", it.req, it.src, it.arg, a, it.exp);
      end
    end
  end

  // host driver: SCK phases of 8 system clocks, MISO sampled before each rise
  task automatic spi_frame(input logic [63:0] bits, input int n);
    got = '0;
    mid_cs = '1;
    repeat (8) @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = bits[n-1-i];
      repeat (8) @(negedge clk);
      got = {got[62:0], miso};
      if (i == 20) mid_cs = dn_cs_n;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_write(logic [6:0] a, logic [15:0] d);
    spi_frame(64'({a, 1'b1, d}), 24);
  endtask

  task automatic reg_check(logic [6:0] a, logic [15:0] exp, string req);
    spi_frame(64'({a, 1'b0, 16'h0}), 24);
    expect_val(0, 0, 32'(exp), req);
    expect_val(7, 0, 32'hF, "R8");
    settle();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // reset state
    for (int c = 0; c < NCH; c++) expect_val(1, c, 0, "R5");
    expect_val(2, 0, 32'hF, "R5");
    expect_val(6, 0, 0, "R5");
    settle();
    reg_check(7'd1, 16'h0, "R5");
    reg_check(7'd2, 16'h0, "R5");
    reg_check(7'd3, 16'h0, "R5");
    // identity register, live status
    reg_check(7'd0, 16'h0A03, "R4");
    // writes and read-back
    reg_write(7'd1, 16'hBEEF);
    reg_check(7'd1, 16'hBEEF, "R2");
    reg_write(7'd3, 16'h1234);
    reg_check(7'd3, 16'h1234, "R3");
    reg_write(7'd2, 16'h8001);
    reg_check(7'd2, 16'h8001, "R1");
    reg_write(7'd0, 16'hFFFF);
    reg_check(7'd0, 16'h0A03, "R4");
    pll_stat = 4'b0101;
    repeat (4) @(negedge clk);
    reg_check(7'd0, 16'h0503, "R4");
    // attenuators, checked 4 clocks after CS_n rises
    spi_frame(64'({7'd9, 1'b0, 8'h5A}), 16);
    expect_val(1, 1, 32'h5A, "R6");
    expect_val(1, 0, 32'h0, "R6");
    settle();
    spi_frame(64'({7'd11, 1'b0, 8'hC3}), 16);
    expect_val(1, 3, 32'hC3, "R11");
    expect_val(1, 1, 32'h5A, "R6");
    settle();
    spi_frame(64'({7'd9, 1'b1, 8'hFF}), 16);
    expect_val(1, 1, 32'h5A, "R6");
    settle();
    // aborted and overlong frames
    spi_frame(64'({7'd2, 1'b1, 12'hABC}), 20);
    reg_check(7'd2, 16'h8001, "R10");
    spi_frame(64'({7'd8, 1'b0, 4'hF}), 12);
    expect_val(1, 0, 32'h0, "R10");
    settle();
    spi_frame(64'({7'd8, 1'b0, 12'hFFF}), 20);
    expect_val(1, 0, 32'h0, "R10");
    settle();
    // undecoded addresses
    spi_frame(64'({7'h30, 1'b0, 16'h0}), 24);
    expect_val(0, 0, 32'h0, "R9");
    expect_val(7, 0, 32'hF, "R9");
    settle();
    spi_frame(64'({7'h30, 1'b1, 16'hFFFF}), 24);
    reg_check(7'd1, 16'hBEEF, "R9");
    reg_check(7'd3, 16'h1234, "R9");
    // passthrough to port 2
    spi_frame(64'({7'd6, 1'b0, 32'hA5C3_0F96}), 40);
    expect_val(0, 0, DS_PAT, "R7");
    expect_val(3, 0, 32'hA5C3_0F96, "R7");
    expect_val(4, 0, 32, "R7");
    expect_val(5, 0, 0, "R8");
    expect_val(7, 0, 32'hB, "R8");
    expect_val(2, 0, 32'hF, "R8");
    settle();
    // passthrough address with flag set is ignored
    spi_frame(64'({7'd6, 1'b1, 32'hFFFF_FFFF}), 40);
    expect_val(4, 0, 32, "R9");
    expect_val(5, 0, 0, "R9");
    expect_val(7, 0, 32'hF, "R9");
    expect_val(0, 0, 32'h0, "R9");
    settle();
    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11: watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule